// File: doc/BRIEF.md
# Stream capture DMA write engine

This block takes a continuous stream of 32-bit words and writes it into a circular buffer in memory using bursts. Incoming words first go into an internal FIFO. When the FIFO holds enough words, the block raises a write request. After a grant it sends a burst of single-cycle writes to consecutive dword addresses. The write pointer wraps to zero at the end of the buffer, so software always sees the buffer as a ring.

One 5-bit packed code sets both the FIFO fill level that raises a request and the longest burst allowed. The buffer is split into two equal halves, and the block marks each time writing finishes a half. A separate 4-bit interval field adds a periodic event each time a power-of-two number of bytes has been written. All events, and FIFO overflow, are kept as sticky status bits that are cleared by writing 1. A single interrupt line is the OR of the event bits that are enabled.

Top module: `strm_cap_dma`

## Requirements
- R1: After synchronous reset, the FIFO is empty, `mem_req`, `mem_we` and `irq` are 0, `wr_ptr` is 0 and all four `irq_status` bits are 0.
- R2: `cfg_code[1:0]` sets the request level: 00 = 4, 01 = 8, 10 = 16 and 11 = 32 dwords. While no burst is running, `mem_req` is 1 exactly when the FIFO holds at least that many words.
- R3: `cfg_code[4:2]` = n sets the burst limit to 2^n dwords (1 to 128). A grant (`mem_req` and `mem_gnt` high at a clock edge) starts a burst on the next cycle. The burst is min(limit, FIFO level at the grant) write cycles in a row, with `mem_we` high in each.
- R4: Each write puts the oldest FIFO word on `mem_wdata` at byte address `mem_addr` = `wr_ptr`. The pointer then advances by 4. It wraps from the last dword of the buffer to 0, and words keep their arrival order.
- R5: `mem_req` is 0 during every cycle of a burst.
- R6: A write that ends the first half of the buffer (the next address would be half the buffer size) sets `irq_status[1]`. A write that ends at the buffer end (the pointer wraps) sets `irq_status[2]`.
- R7: When `limit_sel` = L is in 1..15, every write that brings the running byte total to a multiple of 2^(5+L) sets `irq_status[0]`. When L = 0, `irq_status[0]` is never set.
- R8: Status bits are sticky. A 1 on `irq_clr[i]` clears bit i on the next edge, but an event in the same cycle wins over the clear. `irq` = OR of (`irq_status[2:0]` AND `irq_en`), with bit 0 = periodic, 1 = half, 2 = full.
- R9: If `in_valid` is high while the FIFO already holds FIFO_DEPTH words, that word is dropped and `irq_status[3]` (overflow) is set. Overflow does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream word present this cycle |
| in_data | input | 32 | Stream word |
| cfg_code | input | 5 | [1:0] request level, [4:2] burst limit exponent |
| limit_sel | input | 4 | Periodic interval exponent L (0 = off) |
| irq_en | input | 3 | Interrupt enables: periodic, half, full |
| irq_clr | input | 4 | Write-1-to-clear pulses for the status bits |
| mem_req | output | 1 | Burst write request |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_we | output | 1 | Write strobe, one dword per cycle |
| mem_addr | output | BUF_LOG2 | Byte address of the current write |
| mem_wdata | output | 32 | Data of the current write |
| wr_ptr | output | BUF_LOG2 | Current buffer write pointer (bytes) |
| irq_status | output | 4 | Sticky status: 0 periodic, 1 half, 2 full, 3 overflow |
| irq | output | 1 | Interrupt line |

## Verification
`mem_req`, `mem_we`, `mem_addr`, `mem_wdata`, `wr_ptr` and `irq` follow registered state without any delay. A push shows up in the request decision one cycle after it arrives. A grant shows its first write one cycle later, and a status event or clear shows in `irq_status` one cycle after the write or pulse that caused it. The bench drives inputs just after the falling edge. Shortly after that, it compares every output with a behavioural queue model that has already been stepped by each earlier cycle's inputs. Each comparison therefore lands in the cycle where the result is due. The random traffic phases use several cfg codes, limit values, grant densities and an overflow phase, so they exercise pointer wraps, both buffer marks, periodic events and same-cycle set-and-clear collisions.

// File: rtl/strm_cap_pkg.sv
package strm_cap_pkg;

    localparam int WORD_W    = 32;
    localparam int CFG_W     = 5;
    localparam int LIM_W     = 4;
    localparam int BCNT_W    = 8;   // holds the largest burst (128)
    localparam int SPAN_W    = 20;  // 5 + largest limit (15)
    localparam int ISR_W     = 4;

    typedef enum logic {
        MV_IDLE,
        MV_MOVE
    } mover_st_e;

    // bit 3 .. bit 0 of the status register
    typedef struct packed {
        logic ovf;
        logic full;
        logic half;
        logic per;
    } isr_t;

    function automatic logic [5:0] req_level(input logic [1:0] sel);
        return 6'd4 << sel;
    endfunction

    function automatic logic [BCNT_W-1:0] burst_cap(input logic [2:0] sel);
        return BCNT_W'(1) << sel;
    endfunction

endpackage

// File: rtl/strm_cap_fifo.sv
module strm_cap_fifo
    import strm_cap_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [WORD_W-1:0] din,
    input  logic              pop,
    output logic [WORD_W-1:0] dout,
    output logic [LVL_W-1:0]  level,
    output logic              drop
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [WORD_W-1:0] store [DEPTH];
    logic [IDX_W-1:0]  wr_i;
    logic [IDX_W-1:0]  rd_i;
    logic [LVL_W-1:0]  lvl_q;
    logic              is_full;
    logic              do_push;

    assign is_full = (lvl_q == LVL_W'(DEPTH));
    assign do_push = push_req && !is_full;
    assign drop    = push_req && is_full;
    assign dout    = store[rd_i];
    assign level   = lvl_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_i  <= '0;
            rd_i  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) begin
                wr_i <= wr_i + IDX_W'(1);
            end
            if (pop) begin
                rd_i <= rd_i + IDX_W'(1);
            end
            lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(pop);
        end
    end

    // R3: the mover never reads an empty FIFO
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (lvl_q != '0));

    // R9: a word offered to a full FIFO leaves the level unchanged
    assert_drop_keeps_level_R9: assert property (@(posedge clk) disable iff (rst)
        (push_req && is_full && !pop) |=> (lvl_q == $past(lvl_q)));

endmodule

// File: rtl/strm_cap_mover.sv
module strm_cap_mover
    import strm_cap_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_code,
    input  logic [LVL_W-1:0] level,
    input  logic             mem_gnt,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] ptr_after
);

    mover_st_e         st_q;
    logic [BCNT_W-1:0] rem_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [5:0]        thr;
    logic [BCNT_W-1:0] cap;
    logic [BCNT_W-1:0] take;
    logic              grab;

    assign thr  = req_level(cfg_code[1:0]);
    assign cap  = burst_cap(cfg_code[4:2]);
    assign take = (int'(level) < int'(cap)) ? BCNT_W'(level) : cap;

    assign mem_req   = (st_q == MV_IDLE) && (int'(level) >= int'(thr));
    assign grab      = mem_req && mem_gnt;
    assign mem_we    = (st_q == MV_MOVE);
    assign wr_ptr    = ptr_q;
    assign ptr_after = ptr_q + PTR_W'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= MV_IDLE;
            rem_q <= '0;
            ptr_q <= '0;
        end else begin
            unique case (st_q)
                MV_IDLE: begin
                    if (grab) begin
                        st_q  <= MV_MOVE;
                        rem_q <= take;
                    end
                end
                MV_MOVE: begin
                    ptr_q <= ptr_after;
                    rem_q <= rem_q - BCNT_W'(1);
                    if (rem_q == BCNT_W'(1)) begin
                        st_q <= MV_IDLE;
                    end
                end
                default: st_q <= MV_IDLE;
            endcase
        end
    end

    // R5: no request while a burst is under way
    assert_no_req_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !mem_req);

    // R4: every write advances the pointer by one dword
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (wr_ptr == $past(wr_ptr) + PTR_W'(4)));

    // R3: remaining burst words are always available in the FIFO
    assert_burst_covered_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == MV_MOVE) |-> ((rem_q != '0) && (int'(rem_q) <= int'(level))));

endmodule

// File: rtl/strm_cap_irq.sv
module strm_cap_irq
    import strm_cap_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic [PTR_W-1:0] ptr_after,
    input  logic [LIM_W-1:0] limit_sel,
    input  logic             drop,
    input  logic [2:0]       irq_en,
    input  logic [ISR_W-1:0] irq_clr,
    output logic [ISR_W-1:0] irq_status,
    output logic             irq
);

    localparam logic [PTR_W-1:0] HALF_MARK = PTR_W'(1) << (PTR_W - 1);

    logic [SPAN_W-1:0] span_q;
    logic [SPAN_W-1:0] span_nx;
    logic [SPAN_W-1:0] span_mask;
    logic [ISR_W-1:0]  status_q;
    isr_t              hit;

    assign span_nx   = span_q + SPAN_W'(4);
    assign span_mask = (SPAN_W'(1) << (5 + int'(limit_sel))) - SPAN_W'(1);

    always_comb begin
        hit      = '0;
        hit.per  = wr_fire && (limit_sel != '0) && ((span_nx & span_mask) == '0);
        hit.half = wr_fire && (ptr_after == HALF_MARK);
        hit.full = wr_fire && (ptr_after == '0);
        hit.ovf  = drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            span_q   <= '0;
            status_q <= '0;
        end else begin
            if (wr_fire) begin
                span_q <= span_nx;
            end
            status_q <= (status_q & ~irq_clr) | hit;
        end
    end

    assign irq_status = status_q;
    assign irq        = |(status_q[2:0] & irq_en);

    // R9: overflow stays set until explicitly cleared
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (status_q[3] && !irq_clr[3]) |=> status_q[3]);

    // R8: a clear without a coincident event empties the half bit
    assert_clear_half_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_clr[1] && !hit.half) |=> !status_q[1]);

    // R6: half and full marks never coincide on one write
    assert_marks_apart_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit.half, hit.full}));

endmodule

// File: rtl/strm_cap_dma.sv
module strm_cap_dma
    import strm_cap_pkg::*;
#(
    parameter int BUF_LOG2   = 10,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [CFG_W-1:0]    cfg_code,
    input  logic [LIM_W-1:0]    limit_sel,
    input  logic [2:0]          irq_en,
    input  logic [ISR_W-1:0]    irq_clr,
    output logic                mem_req,
    input  logic                mem_gnt,
    output logic                mem_we,
    output logic [BUF_LOG2-1:0] mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [BUF_LOG2-1:0] wr_ptr,
    output logic [ISR_W-1:0]    irq_status,
    output logic                irq
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [LVL_W-1:0]    level;
    logic                drop;
    logic [BUF_LOG2-1:0] ptr_after;
    logic [BUF_LOG2-1:0] ptr_now;

    strm_cap_fifo #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_req (in_valid),
        .din      (in_data),
        .pop      (mem_we),
        .dout     (mem_wdata),
        .level    (level),
        .drop     (drop)
    );

    strm_cap_mover #(
        .PTR_W (BUF_LOG2),
        .LVL_W (LVL_W)
    ) u_mover (
        .clk       (clk),
        .rst       (rst),
        .cfg_code  (cfg_code),
        .level     (level),
        .mem_gnt   (mem_gnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .wr_ptr    (ptr_now),
        .ptr_after (ptr_after)
    );

    strm_cap_irq #(
        .PTR_W (BUF_LOG2)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (mem_we),
        .ptr_after  (ptr_after),
        .limit_sel  (limit_sel),
        .drop       (drop),
        .irq_en     (irq_en),
        .irq_clr    (irq_clr),
        .irq_status (irq_status),
        .irq        (irq)
    );

    assign mem_addr = ptr_now;
    assign wr_ptr   = ptr_now;

endmodule

// File: tb/strm_cap_dma_test.sv
module strm_cap_dma_test;
    import strm_cap_pkg::*;

    localparam int BUF_LOG2 = 10;
    localparam int DEPTH    = 64;
    localparam int BUFB     = 1 << BUF_LOG2;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic [31:0]         in_data;
    logic [4:0]          cfg_code;
    logic [3:0]          limit_sel;
    logic [2:0]          irq_en;
    logic [3:0]          irq_clr;
    logic                mem_req;
    logic                mem_gnt;
    logic                mem_we;
    logic [BUF_LOG2-1:0] mem_addr;
    logic [31:0]         mem_wdata;
    logic [BUF_LOG2-1:0] wr_ptr;
    logic [3:0]          irq_status;
    logic                irq;

    always #2.5 clk = ~clk;

    strm_cap_dma #(.BUF_LOG2(BUF_LOG2), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cfg_code(cfg_code), .limit_sel(limit_sel), .irq_en(irq_en),
        .irq_clr(irq_clr), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_ptr(wr_ptr), .irq_status(irq_status), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    logic [31:0] q[$];
    bit          m_burst;
    int          m_rem;
    int          m_ptr;
    int          m_span;
    bit [3:0]    m_st;
    int unsigned wcnt;

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        m_burst = 0;
        m_rem   = 0;
        m_ptr   = 0;
        m_span  = 0;
        m_st    = '0;
    endtask

    task automatic cycle(bit v, bit g, bit [3:0] clr);
        int       thr;
        int       blen;
        int       pre;
        bit       exp_req;
        bit [3:0] ev;
        logic [31:0] w;
        w         = wcnt * 32'h9E3779B1 + 32'h1234;
        in_valid  = v;
        in_data   = v ? w : 32'h0;
        mem_gnt   = g;
        irq_clr   = clr;
        #1;
        thr     = 4 << cfg_code[1:0];
        blen    = 1 << cfg_code[4:2];
        exp_req = !m_burst && (q.size() >= thr);
        if (m_burst) chk("R5 mem_req low in burst", mem_req, 0);
        else         chk("R2 mem_req level", mem_req, exp_req);
        chk("R3 mem_we", mem_we, m_burst);
        if (m_burst) begin
            chk("R4 mem_wdata", mem_wdata, q[0]);
            chk("R4 mem_addr", mem_addr, m_ptr);
        end
        chk("R4 wr_ptr", wr_ptr, m_ptr);
        chk("R7 periodic bit", irq_status[0], m_st[0]);
        chk("R6 half/full bits", irq_status[2:1], m_st[2:1]);
        chk("R9 overflow bit", irq_status[3], m_st[3]);
        chk("R8 irq line", irq, |(m_st[2:0] & irq_en));
        // next state
        pre = q.size();
        ev  = '0;
        if (m_burst) begin
            void'(q.pop_front());
            m_ptr  = (m_ptr + 4) % BUFB;
            m_span = (m_span + 4) % (1 << 20);
            if (m_ptr == BUFB / 2) ev[1] = 1;
            if (m_ptr == 0) ev[2] = 1;
            if (limit_sel != 0 && (m_span % (1 << (5 + limit_sel))) == 0) ev[0] = 1;
            m_rem--;
            if (m_rem == 0) m_burst = 0;
        end else if (exp_req && g) begin
            m_burst = 1;
            m_rem   = (pre < blen) ? pre : blen;
        end
        if (v) begin
            wcnt++;
            if (pre == DEPTH) ev[3] = 1;
            else q.push_back(w);
        end
        m_st = (m_st & ~clr) | ev;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n, int pv, int pg, int pc);
        for (int i = 0; i < n; i++) begin
            bit [3:0] c;
            c = '0;
            for (int b = 0; b < 4; b++) begin
                if ($urandom_range(0, 99) < pc) c[b] = 1'b1;
            end
            cycle($urandom_range(0, 99) < pv, $urandom_range(0, 99) < pg, c);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; in_data = 0; mem_gnt = 0; irq_clr = 0;
        cfg_code = 5'h03; limit_sel = 4'd3; irq_en = 3'b111;
        wcnt = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 mem_req", mem_req, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 irq_status", irq_status, 0);
        chk("R1 irq", irq, 0);
        @(negedge clk);

        // 32-dword level, 1-dword bursts, 256-byte periodic events
        cfg_code = 5'h03; limit_sel = 4'd3; irq_en = 3'b111;
        run(1500, 40, 100, 2);
        // 4-dword level, 128-dword bursts, periodic off
        cfg_code = 5'h1c; limit_sel = 4'd0;
        run(3000, 70, 50, 3);
        // 8-dword level, 4-dword bursts, 64-byte events, only periodic enabled
        cfg_code = 5'h09; limit_sel = 4'd1; irq_en = 3'b001;
        run(3000, 50, 80, 4);
        // R9: overflow with grant withheld, then clear and drain
        irq_en = 3'b110;
        for (int i = 0; i < 80; i++) cycle(1, 0, 4'b0000);
        cycle(0, 0, 4'b1000);
        cycle(0, 0, 4'b0000);
        for (int i = 0; i < 300; i++) cycle(0, 1, 4'b0000);
        // 16-dword level, 16-dword bursts, 512-byte events, busy clears
        cfg_code = 5'h12; limit_sel = 4'd4;
        run(4000, 60, 70, 6);
        // largest interval, all enabled
        cfg_code = 5'h0d; limit_sel = 4'd15; irq_en = 3'b111;
        run(1500, 55, 90, 3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule